// File: doc/BRIEF.md
# Dual-Mode Power-Up Sequencer

This block is a state machine that runs from a slow timebase of roughly 32 kHz and brings a device's internal supplies up in a fixed order. It chooses between two start-up paths.

- **Host-selected path.** The part is selected and its battery and I/O rails are present. The sequence ends by releasing the internal power-on reset and enabling the PLL. It then keeps the bus-direction output high until the PLL reports lock, so the attached link controller knows when it may start configuring the device.
- **Charger path.** The part is not selected, but a cable is present and charging is allowed. The same supply sequence runs, but reset stays asserted and the PLL stays off. The block issues a one-cycle start pulse to a separate charger-detection engine.

Each step waits a fixed number of slow-clock cycles. A failed power-good check during the supply debounce window moves the machine to an error dwell of several thousand cycles. After that dwell it retries from the off state. If the entry condition of the active path disappears at any point, every enable drops at once.

Top module: `pwr_seq`

## Requirements
- R1: While `rst_n` is low: `reg_en` is 3'b000, `por_rel` is 0, `pll_en` is 0, `dir_o` is 1 and `chg_start` is 0.
- R2: The host-selected path starts when `sel_hi`=1, `sel_lo_n`=0, `batt_ok`=1 and `io_ok`=1. If either select form is not asserted, this path is not taken.
- R3: The charger path starts when the part is not selected (`sel_hi`=0 or `sel_lo_n`=1), `vbus_ok`=1, `chg_en_n`=0 and `batt_ok`=1. When the part is selected, the host path is taken instead.
- R4: Edge 1 is the first clock edge that sees a valid entry condition. The two core enables (`reg_en` bits 1:0) rise after edge 6, which follows a 2-cycle control-reset wait and a 3-cycle monitor-enable wait.
- R5: After a 6-cycle supply debounce and a 3-cycle wait, the 3.3 V enable (`reg_en` bit 2) rises after edge 15. Bit 2 is never high while bits 1:0 are low.
- R6: After a further 4-cycle reset wait, the common "USB on" state is reached after edge 19.
- R7: On the host path in "USB on", `por_rel`=1 and `pll_en`=1. `dir_o` stays 1 until `pll_lock` is 1 and is 0 while lock is held.
- R8: On the charger path in "USB on", `por_rel`=0 and `pll_en`=0, and `dir_o` stays 1 whatever `pll_lock` is. `chg_start` is 1 for exactly the first cycle of "USB on".
- R9: A clock edge during the debounce window that sees either bit of `pgood` low clears all enables after that edge. The machine then waits the error dwell E. It re-enters the sequence, and the core enables rise again after edge f+E+6, where f is the faulting edge.
- R10: A `pgood` drop outside the debounce window has no effect on the outputs.
- R11: If the entry condition of the active path is false at a clock edge, the next output state is the R1 state. This applies in every state other than off.
- R12: The error dwell E is the parameter `ERR_CYC` clamped into the range 4100 to 8196 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_hi | input | 1 | Chip select, active-high form |
| sel_lo_n | input | 1 | Chip select, active-low form |
| vbus_ok | input | 1 | Cable supply present |
| chg_en_n | input | 1 | Charger detection allowed, active low |
| batt_ok | input | 1 | Battery above monitor level |
| io_ok | input | 1 | I/O supply present |
| pgood | input | 2 | Power-good flags of the two core regulators |
| pll_lock | input | 1 | PLL locked |
| reg_en | output | 3 | Regulator enables: bits 1:0 core, bit 2 the 3.3 V rail |
| por_rel | output | 1 | Internal power-on reset released |
| pll_en | output | 1 | PLL enable |
| dir_o | output | 1 | Bus-direction output, high while the device owns the bus |
| chg_start | output | 1 | One-cycle start pulse for charger detection |

## Verification
The bench builds three instances that share every input.

- The main instance uses `ERR_CYC`=4100, the low end of the allowed range. This keeps a full fault, dwell and retry cycle short enough to be timed to the exact edge.
- A second instance uses `ERR_CYC`=10, so it must clamp up and restart on the same edge as the main instance.
- A third instance uses `ERR_CYC`=9000, so it must clamp down and restart exactly 4096 cycles later.

All step delays keep their default values. This lets the bench check the output state after every edge of the sequence against the cycle counts in R4 to R6.

// File: rtl/pwr_seq.sv
`timescale 1ns/1ps
module pwr_seq #(
  parameter int T_PC    = 2,
  parameter int T_MON   = 3,
  parameter int T_DEB   = 6,
  parameter int T_R33   = 3,
  parameter int T_RST   = 4,
  parameter int ERR_CYC = 4100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_hi,
  input  logic       sel_lo_n,
  input  logic       vbus_ok,
  input  logic       chg_en_n,
  input  logic       batt_ok,
  input  logic       io_ok,
  input  logic [1:0] pgood,
  input  logic       pll_lock,
  output logic [2:0] reg_en,
  output logic       por_rel,
  output logic       pll_en,
  output logic       dir_o,
  output logic       chg_start
);
  localparam int ERR_LO  = 4100;
  localparam int ERR_HI  = 8196;
  localparam int ERR_EFF = (ERR_CYC < ERR_LO) ? ERR_LO : (ERR_CYC > ERR_HI) ? ERR_HI : ERR_CYC;
  localparam int CW      = $clog2(ERR_HI + 1);

  typedef enum logic [2:0] {S_OFF, S_PCR, S_MON, S_DEB, S_R33, S_RST, S_ON, S_ERR} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, lim;
  logic          chg_mode, first_q;

  wire sel     = sel_hi & ~sel_lo_n;
  wire go_norm = sel & batt_ok & io_ok;
  wire go_chg  = ~sel & vbus_ok & ~chg_en_n & batt_ok;
  wire hold    = chg_mode ? go_chg : go_norm;
  wire done    = (cnt == lim);
  wire fault   = (st == S_DEB) && (pgood != 2'b11);

  always_comb begin
    case (st)
      S_PCR:   lim = CW'(T_PC - 1);
      S_MON:   lim = CW'(T_MON - 1);
      S_DEB:   lim = CW'(T_DEB - 1);
      S_R33:   lim = CW'(T_R33 - 1);
      S_RST:   lim = CW'(T_RST - 1);
      S_ERR:   lim = CW'(ERR_EFF - 1);
      default: lim = '0;
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_OFF: if (go_norm || go_chg) st_nx = S_PCR;
      S_PCR: if (done) st_nx = S_MON;
      S_MON: if (done) st_nx = S_DEB;
      S_DEB: if (fault) st_nx = S_ERR;
             else if (done) st_nx = S_R33;
      S_R33: if (done) st_nx = S_RST;
      S_RST: if (done) st_nx = S_ON;
      S_ERR: if (done) st_nx = S_OFF;
      default: ;
    endcase
    if (st != S_OFF && !hold) st_nx = S_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      cnt      <= '0;
      chg_mode <= 1'b0;
      first_q  <= 1'b1;
    end else begin
      st      <= st_nx;
      cnt     <= (st_nx != st) ? '0 : cnt + 1'b1;
      first_q <= (st != S_ON);
      if (st == S_OFF) chg_mode <= ~go_norm & go_chg;
    end
  end

  wire core_up = (st == S_DEB) || (st == S_R33) || (st == S_RST) || (st == S_ON);
  wire hv_up   = (st == S_RST) || (st == S_ON);
  wire on_host = (st == S_ON) && !chg_mode;

  assign reg_en    = {hv_up, core_up, core_up};
  assign por_rel   = on_host;
  assign pll_en    = on_host;
  assign dir_o     = ~(on_host & pll_lock);
  assign chg_start = (st == S_ON) && chg_mode && first_q;
endmodule

module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_hi,
  input logic       sel_lo_n,
  input logic       batt_ok,
  input logic       pll_lock,
  input logic [2:0] reg_en,
  input logic       por_rel,
  input logic       pll_en,
  input logic       dir_o,
  input logic       chg_start
);
  assert_hv_needs_core_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en[2] |-> reg_en[1:0] == 2'b11);
  assert_hv_after_core_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en[2]) |-> $past(reg_en[1:0]) == 2'b11);
  assert_on_after_hv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_rel) |-> $past(reg_en[2]));
  assert_host_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    por_rel |-> (reg_en == 3'b111) && pll_en);
  assert_dir_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_o |-> pll_lock && por_rel);
  assert_host_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    por_rel |-> $past(sel_hi && !sel_lo_n));
  assert_chg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_start |-> !por_rel && !pll_en && dir_o && reg_en == 3'b111);
  assert_chg_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_start |=> !chg_start);
  assert_batt_loss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en != 3'b000 && !batt_ok) |=> reg_en == 3'b000);
endmodule

bind pwr_seq pwr_seq_chk chk_i (.*);

// File: tb/pwr_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_hi = 0, sel_lo_n = 1, vbus_ok = 0, chg_en_n = 1, batt_ok = 0, io_ok = 0;
  logic [1:0] pgood = 2'b11;
  logic pll_lock = 0;

  logic [2:0] reg_en_i, reg_en_c, reg_en_h;
  logic por_i, pll_i, dir_i, cs_i;
  logic por_c, pll_c, dir_c, cs_c;
  logic por_h, pll_h, dir_h, cs_h;

  int errs = 0, checks = 0, n = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_seq dut_i (.clk, .rst_n, .sel_hi, .sel_lo_n, .vbus_ok, .chg_en_n, .batt_ok, .io_ok,
    .pgood, .pll_lock, .reg_en(reg_en_i), .por_rel(por_i), .pll_en(pll_i), .dir_o(dir_i), .chg_start(cs_i));
  pwr_seq #(.ERR_CYC(10)) dut_c (.clk, .rst_n, .sel_hi, .sel_lo_n, .vbus_ok, .chg_en_n, .batt_ok, .io_ok,
    .pgood, .pll_lock, .reg_en(reg_en_c), .por_rel(por_c), .pll_en(pll_c), .dir_o(dir_c), .chg_start(cs_c));
  pwr_seq #(.ERR_CYC(9000)) dut_h (.clk, .rst_n, .sel_hi, .sel_lo_n, .vbus_ok, .chg_en_n, .batt_ok, .io_ok,
    .pgood, .pll_lock, .reg_en(reg_en_h), .por_rel(por_h), .pll_en(pll_h), .dir_o(dir_h), .chg_start(cs_h));

  // {sel_hi, sel_lo_n, vbus_ok, chg_en_n, batt_ok, io_ok, path[1:0]}; path 0 none, 1 host, 2 charger
  localparam logic [7:0] VEC [12] = '{
    8'b10011101, 8'b11011100, 8'b00011100, 8'b10101101,
    8'b10011000, 8'b10010100, 8'b01101010, 8'b00101110,
    8'b11101110, 8'b01111100, 8'b01001100, 8'b01100100 };

  localparam logic [5:0] HOST = 6'b100111;
  localparam logic [5:0] CHG  = 6'b011010;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic [5:0] s);
    {sel_hi, sel_lo_n, vbus_ok, chg_en_n, batt_ok, io_ok} = s;
  endtask

  task automatic do_reset(input logic [5:0] s);
    rst_n = 0;
    set_in(s);
    pgood = 2'b11;
    pll_lock = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    n = 0;
  endtask

  task automatic adv_to(input int t);
    repeat (t - n) @(posedge clk);
    n = t;
    @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    rst_n = 0;
    set_in(HOST);
    repeat (3) @(negedge clk);
    chk("R1 reg_en", reg_en_i, 0);
    chk("R1 por_rel", por_i, 0);
    chk("R1 pll_en", pll_i, 0);
    chk("R1 dir_o", dir_i, 1);
    chk("R1 chg_start", cs_i, 0);

    // R2 R3 R4: entry-condition table
    foreach (VEC[k]) begin
      logic [1:0] p;
      p = VEC[k][1:0];
      do_reset(VEC[k][7:2]);
      adv_to(5);
      chk("R4 early", reg_en_i, 0);
      adv_to(6);
      chk(p == 2 ? "R3 core en" : "R2 core en", reg_en_i, p != 0 ? 3 : 0);
      adv_to(19);
      chk(p == 2 ? "R3 por" : "R2 por", por_i, p == 1 ? 1 : 0);
      chk(p == 2 ? "R3 pll" : "R2 pll", pll_i, p == 1 ? 1 : 0);
      chk(p == 2 ? "R3 rails" : "R2 rails", reg_en_i, p != 0 ? 7 : 0);
    end

    // R4 R5 R6: every step, host path
    do_reset(HOST);
    for (int e = 1; e <= 20; e++) begin
      adv_to(e);
      chk(e < 6 ? "R4 step" : "R5 step", reg_en_i, e < 6 ? 0 : (e < 15 ? 3 : 7));
      chk("R6 usb on", por_i, e >= 19 ? 1 : 0);
    end

    // R7 direction handshake
    chk("R7 dir before lock", dir_i, 1);
    chk("R7 pll_en", pll_i, 1);
    pll_lock = 1;
    adv_to(21);
    chk("R7 dir on lock", dir_i, 0);
    pll_lock = 0;
    adv_to(22);
    chk("R7 dir lock lost", dir_i, 1);

    // R8 charger hand-off
    do_reset(CHG);
    adv_to(18);
    chk("R8 no early pulse", cs_i, 0);
    adv_to(19);
    chk("R8 pulse", cs_i, 1);
    chk("R8 por held", por_i, 0);
    chk("R8 pll off", pll_i, 0);
    chk("R8 rails", reg_en_i, 7);
    adv_to(20);
    chk("R8 pulse width", cs_i, 0);
    pll_lock = 1;
    adv_to(21);
    chk("R8 dir ignores lock", dir_i, 1);
    pll_lock = 0;

    // R11 loss of entry condition
    vbus_ok = 0;
    adv_to(22);
    chk("R11 charger loss", reg_en_i, 0);
    do_reset(HOST);
    adv_to(16);
    sel_lo_n = 1;
    adv_to(17);
    chk("R11 host loss rails", reg_en_i, 0);
    chk("R11 host loss por", por_i, 0);
    adv_to(25);
    chk("R11 stays off", reg_en_i, 0);

    // R10 pgood drop after debounce
    do_reset(HOST);
    adv_to(13);
    pgood = 2'b01;
    adv_to(19);
    chk("R10 rails kept", reg_en_i, 7);
    chk("R10 por kept", por_i, 1);

    // R9 R12 fault, dwell and clamp
    do_reset(HOST);
    adv_to(8);
    pgood = 2'b10;
    adv_to(9);
    chk("R9 fault off", reg_en_i, 0);
    pgood = 2'b11;
    adv_to(4114);
    chk("R9 dwell", reg_en_i, 0);
    chk("R12 low clamp dwell", reg_en_c, 0);
    adv_to(4115);
    chk("R9 retry", reg_en_i, 3);
    chk("R12 low clamp retry", reg_en_c, 3);
    chk("R12 high clamp still", reg_en_h, 0);
    adv_to(8210);
    chk("R12 high clamp dwell", reg_en_h, 0);
    adv_to(8211);
    chk("R12 high clamp retry", reg_en_h, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule